// File: doc/BRIEF.md
# Interrupt Priority Claim Engine

This block is the arbitration core of a platform-level interrupt controller. It samples a vector of level-sensitive interrupt sources and keeps a pending bit and a claimed bit for each one. It also stores a priority for each source, an enable mask for each context and a priority threshold for each context. Every context gets one interrupt-request line. That line is high when some source the context may take has a priority strictly above the context's threshold.

A context services an interrupt in two steps. First it pulses the claim port. One cycle later the engine returns the winning source ID and marks that source as owned, which hides it from every context. After servicing the source, the context writes the ID to the completion port, and the source can then interrupt again. ID 0 is reserved and means "nothing to service". Configuration is loaded through three simple write strobes: one for source priority, one for the enable mask and one for the threshold. Reset is synchronous and active high.

Top module: `prio_claim_engine`

## Requirements
- R1: A source counts for a context only if three things hold: its pending bit is set, its claimed bit is clear, and bit i of that context's enable mask is set, where i is the source ID.
- R2: `irq[c]` is high exactly when at least one source that counts for context c has a priority strictly greater than that context's threshold. Equality does not raise the line.
- R3: A claim returns the source that counts for the context and has the largest priority above the threshold. On a tie between equal priorities, the smallest ID wins.
- R4: `claim_ack` is high in the cycle after `claim_req` and carries `claim_id`. A nonzero result marks that source claimed. While it is claimed, it raises no request and no context can claim it, even if its input stays high.
- R5: A claim returns ID 0 when nothing qualifies, and a zero result changes no state.
- R6: A completion with an ID below NUM_SRC clears that source's claimed bit. An ID of NUM_SRC or more has no effect.
- R7: The pending bit follows the source level with one register stage. When the input drops, the request goes away and a claim returns 0.
- R8: A source with priority 0 never raises a request. Source 0 never takes part in arbitration.
- R9: Reset clears pending, claimed, priorities, enable masks and thresholds, so every request line and the claim outputs read 0 afterwards.
- R10: A write to a priority, enable mask or threshold, and a completion, all show on `irq` in the cycle right after the clock edge that takes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | NUM_SRC | Source levels, bit i is source i |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | ID_W | Source whose priority is written |
| prio_val | input | PRIO_W | Priority value |
| en_we | input | 1 | Enable mask write strobe |
| en_ctx | input | CTX_W | Context whose mask is written |
| en_val | input | NUM_SRC | Enable mask, bit i enables source i |
| thr_we | input | 1 | Threshold write strobe |
| thr_ctx | input | CTX_W | Context whose threshold is written |
| thr_val | input | PRIO_W | Threshold value |
| claim_req | input | 1 | Claim request pulse |
| claim_ctx | input | CTX_W | Context making the claim |
| claim_ack | output | 1 | Claim result valid |
| claim_id | output | ID_W | Claimed source ID, 0 when none |
| cmpl_req | input | 1 | Completion strobe |
| cmpl_id | input | ID_W+1 | Source ID being completed |
| irq | output | NUM_CTX | Request line per context |

## Verification
The bench targets four kinds of corner case:
- Priority ties. A design that picks the highest ID on a tie returns the wrong source.
- A threshold equal to the priority. A design that compares with "greater or equal" raises a request it should not.
- A source claimed while its input is still high. A design that forgets to mask it claims the same source twice.
- Completion IDs out of range. A design that does not range-check them releases a source by wrapping the ID.

The bench also covers a claim by one context hiding the source from the other, priority-0 sources, source 0, and a request that drops before it is claimed. A design that got any of these wrong would return a nonzero ID or raise a line where 0 is expected.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int unsigned PCE_PRIO_W_DEF = 3;
  localparam int unsigned PCE_NUM_SRC_DEF = 32;
  localparam int unsigned PCE_NUM_CTX_DEF = 2;

  function automatic int unsigned pce_sel_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pce_src_state.sv
module pce_src_state
  import pce_pkg::*;
#(
  parameter int unsigned NUM_SRC = PCE_NUM_SRC_DEF,
  parameter int unsigned PRIO_W  = PCE_PRIO_W_DEF,
  localparam int unsigned ID_W   = pce_sel_w(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              src_lvl,
  input  logic                            prio_we,
  input  logic [ID_W-1:0]                 prio_sel,
  input  logic [PRIO_W-1:0]               prio_val,
  input  logic                            take_en,
  input  logic [ID_W-1:0]                 take_id,
  input  logic                            free_en,
  input  logic [ID_W-1:0]                 free_id,
  output logic [NUM_SRC-1:0]              pend_q,
  output logic [NUM_SRC-1:0]              clm_q,
  output logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q
);
  logic [NUM_SRC-1:0] pend_n, clm_n;

  always_comb begin
    pend_n = src_lvl;
    clm_n  = clm_q;
    if (free_en) clm_n[free_id] = 1'b0;
    if (take_en) begin
      clm_n[take_id]  = 1'b1;
      pend_n[take_id] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      clm_q  <= '0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_n;
      clm_q  <= clm_n;
      if (prio_we) prio_q[prio_sel] <= prio_val;
    end
  end
endmodule

// File: rtl/pce_ctx_cfg.sv
module pce_ctx_cfg
  import pce_pkg::*;
#(
  parameter int unsigned NUM_SRC = PCE_NUM_SRC_DEF,
  parameter int unsigned NUM_CTX = PCE_NUM_CTX_DEF,
  parameter int unsigned PRIO_W  = PCE_PRIO_W_DEF,
  localparam int unsigned CTX_W  = pce_sel_w(NUM_CTX)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             en_we,
  input  logic [CTX_W-1:0]                 en_ctx,
  input  logic [NUM_SRC-1:0]               en_val,
  input  logic                             thr_we,
  input  logic [CTX_W-1:0]                 thr_ctx,
  input  logic [PRIO_W-1:0]                thr_val,
  output logic [NUM_CTX-1:0][NUM_SRC-1:0]  en_q,
  output logic [NUM_CTX-1:0][PRIO_W-1:0]   thr_q
);
  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[c]  <= '0;
        thr_q[c] <= '0;
      end else begin
        if (en_we && en_ctx == CTX_W'(c))   en_q[c]  <= en_val;
        if (thr_we && thr_ctx == CTX_W'(c)) thr_q[c] <= thr_val;
      end
    end
  end
endmodule

// File: rtl/pce_arbiter.sv
module pce_arbiter
  import pce_pkg::*;
#(
  parameter int unsigned NUM_SRC = PCE_NUM_SRC_DEF,
  parameter int unsigned PRIO_W  = PCE_PRIO_W_DEF,
  localparam int unsigned ID_W   = pce_sel_w(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]              elig,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio,
  input  logic [PRIO_W-1:0]               thr,
  output logic [ID_W-1:0]                 best_id,
  output logic                            hit
);
  logic [PRIO_W-1:0] best_p;

  // Ascending scan; only a strictly larger priority displaces the holder,
  // so equal priorities resolve to the smaller ID. Source 0 is skipped.
  always_comb begin
    best_p  = thr;
    best_id = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig[i] && prio[i] > best_p) begin
        best_p  = prio[i];
        best_id = ID_W'(i);
      end
    end
  end

  assign hit = (best_id != '0);
endmodule

// File: rtl/prio_claim_engine.sv
module prio_claim_engine
  import pce_pkg::*;
#(
  parameter int unsigned NUM_SRC = PCE_NUM_SRC_DEF,
  parameter int unsigned NUM_CTX = PCE_NUM_CTX_DEF,
  parameter int unsigned PRIO_W  = PCE_PRIO_W_DEF,
  localparam int unsigned ID_W   = pce_sel_w(NUM_SRC),
  localparam int unsigned CTX_W  = pce_sel_w(NUM_CTX)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic               prio_we,
  input  logic [ID_W-1:0]    prio_sel,
  input  logic [PRIO_W-1:0]  prio_val,
  input  logic               en_we,
  input  logic [CTX_W-1:0]   en_ctx,
  input  logic [NUM_SRC-1:0] en_val,
  input  logic               thr_we,
  input  logic [CTX_W-1:0]   thr_ctx,
  input  logic [PRIO_W-1:0]  thr_val,
  input  logic               claim_req,
  input  logic [CTX_W-1:0]   claim_ctx,
  output logic               claim_ack,
  output logic [ID_W-1:0]    claim_id,
  input  logic               cmpl_req,
  input  logic [ID_W:0]      cmpl_id,
  output logic [NUM_CTX-1:0] irq
);
  logic [NUM_SRC-1:0]              pend_q, clm_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_q;
  logic [NUM_CTX-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_CTX-1:0][PRIO_W-1:0]  thr_q;
  logic [NUM_CTX-1:0][ID_W-1:0]    best_id;
  logic [ID_W-1:0]                 win_id;
  logic                            take_en, free_en;

  assign win_id  = (int'(claim_ctx) < NUM_CTX) ? best_id[claim_ctx] : '0;
  assign take_en = claim_req && (win_id != '0);
  assign free_en = cmpl_req && (int'(cmpl_id) < NUM_SRC);

  pce_src_state #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_state (
    .clk(clk), .rst(rst), .src_lvl(src_lvl),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_val(prio_val),
    .take_en(take_en), .take_id(win_id),
    .free_en(free_en), .free_id(cmpl_id[ID_W-1:0]),
    .pend_q(pend_q), .clm_q(clm_q), .prio_q(prio_q)
  );

  pce_ctx_cfg #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX), .PRIO_W(PRIO_W)) u_cfg (
    .clk(clk), .rst(rst),
    .en_we(en_we), .en_ctx(en_ctx), .en_val(en_val),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
    .en_q(en_q), .thr_q(thr_q)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_arb
    pce_arbiter #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_arb (
      .elig(pend_q & ~clm_q & en_q[c]),
      .prio(prio_q),
      .thr(thr_q[c]),
      .best_id(best_id[c]),
      .hit(irq[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      claim_ack <= 1'b0;
      claim_id  <= '0;
    end else begin
      claim_ack <= claim_req;
      if (claim_req) claim_id <= win_id;
    end
  end
endmodule

// File: rtl/pce_checker.sv
module pce_checker
  import pce_pkg::*;
#(
  parameter int unsigned NUM_SRC = PCE_NUM_SRC_DEF,
  parameter int unsigned NUM_CTX = PCE_NUM_CTX_DEF,
  localparam int unsigned ID_W   = pce_sel_w(NUM_SRC),
  localparam int unsigned CTX_W  = pce_sel_w(NUM_CTX)
) (
  input logic               clk,
  input logic               rst,
  input logic               claim_req,
  input logic [CTX_W-1:0]   claim_ctx,
  input logic               claim_ack,
  input logic [ID_W-1:0]    claim_id,
  input logic               cmpl_req,
  input logic [NUM_CTX-1:0] irq
);
  a_r4_ack_follows: assert property (@(posedge clk) disable iff (rst)
    claim_req |=> claim_ack);

  a_r4_no_stray_ack: assert property (@(posedge clk) disable iff (rst)
    !claim_req |=> !claim_ack);

  a_r4_no_double_take: assert property (@(posedge clk) disable iff (rst)
    (claim_ack && claim_id != '0 && claim_req && !cmpl_req)
    |=> (claim_id != $past(claim_id)));

  a_r5_zero_when_idle: assert property (@(posedge clk) disable iff (rst)
    (claim_req && int'(claim_ctx) < NUM_CTX && !irq[claim_ctx])
    |=> (claim_id == '0));

  a_r3_winner_when_req: assert property (@(posedge clk) disable iff (rst)
    (claim_req && int'(claim_ctx) < NUM_CTX && irq[claim_ctx])
    |=> (claim_id != '0));

  a_r9_reset_quiet: assert property (@(posedge clk)
    rst |=> (irq == '0 && !claim_ack && claim_id == '0));
endmodule

bind prio_claim_engine pce_checker #(.NUM_SRC(NUM_SRC), .NUM_CTX(NUM_CTX)) u_chk (
  .clk(clk), .rst(rst), .claim_req(claim_req), .claim_ctx(claim_ctx),
  .claim_ack(claim_ack), .claim_id(claim_id), .cmpl_req(cmpl_req), .irq(irq)
);

// File: tb/prio_claim_engine_tb.sv
module prio_claim_engine_tb;
  localparam int NS = 32;
  localparam int NC = 2;
  localparam int PW = 3;
  localparam int IW = 5;
  localparam int CW = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NS-1:0] src_lvl = '0;
  logic prio_we = 0; logic [IW-1:0] prio_sel = '0; logic [PW-1:0] prio_val = '0;
  logic en_we = 0;   logic [CW-1:0] en_ctx = '0;   logic [NS-1:0] en_val = '0;
  logic thr_we = 0;  logic [CW-1:0] thr_ctx = '0;  logic [PW-1:0] thr_val = '0;
  logic claim_req = 0; logic [CW-1:0] claim_ctx = '0;
  logic claim_ack; logic [IW-1:0] claim_id;
  logic cmpl_req = 0; logic [IW:0] cmpl_id = '0;
  logic [NC-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  prio_claim_engine #(.NUM_SRC(NS), .NUM_CTX(NC), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst(rst), .src_lvl(src_lvl),
    .prio_we(prio_we), .prio_sel(prio_sel), .prio_val(prio_val),
    .en_we(en_we), .en_ctx(en_ctx), .en_val(en_val),
    .thr_we(thr_we), .thr_ctx(thr_ctx), .thr_val(thr_val),
    .claim_req(claim_req), .claim_ctx(claim_ctx),
    .claim_ack(claim_ack), .claim_id(claim_id),
    .cmpl_req(cmpl_req), .cmpl_id(cmpl_id), .irq(irq)
  );

  // {level mask, context-0 threshold, expected winner}; source i has priority i%8
  localparam logic [39:0] VEC [9] = '{
    {32'h0000_0028, 3'd0, 5'd5},
    {32'h0000_8080, 3'd0, 5'd7},
    {32'h8000_8000, 3'd6, 5'd15},
    {32'h0000_1010, 3'd4, 5'd0},
    {32'h0001_0100, 3'd0, 5'd0},
    {32'h0004_0200, 3'd0, 5'd18},
    {32'h0000_004E, 3'd5, 5'd6},
    {32'h0000_0001, 3'd0, 5'd0},
    {32'h0040_4000, 3'd0, 5'd14}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_prio(input int id, input int v);
    prio_we = 1; prio_sel = IW'(id); prio_val = PW'(v); tick(); prio_we = 0;
  endtask

  task automatic wr_en(input int c, input logic [NS-1:0] m);
    en_we = 1; en_ctx = CW'(c); en_val = m; tick(); en_we = 0;
  endtask

  task automatic wr_thr(input int c, input int v);
    thr_we = 1; thr_ctx = CW'(c); thr_val = PW'(v); tick(); thr_we = 0;
  endtask

  task automatic set_lvl(input logic [NS-1:0] m);
    src_lvl = m; tick();
  endtask

  task automatic claim(input int c, output int id);
    claim_req = 1; claim_ctx = CW'(c); tick(); claim_req = 0;
    chk("R4 ack", 32'(claim_ack), 32'd1);
    id = int'(claim_id);
  endtask

  task automatic cmpl(input int id);
    cmpl_req = 1; cmpl_id = (IW+1)'(id); tick(); cmpl_req = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int id;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    tick();
    chk("R9 irq after reset", 32'(irq), 32'd0);
    chk("R9 ack after reset", 32'(claim_ack), 32'd0);
    chk("R9 id after reset", 32'(claim_id), 32'd0);

    for (int i = 0; i < NS; i++) wr_prio(i, i % 8);
    wr_en(0, '1);
    wr_en(1, '0);
    wr_thr(1, 0);

    // table walk: arbitration R2 R3 R5 R8
    for (int v = 0; v < 9; v++) begin
      wr_thr(0, int'(VEC[v][7:5]));
      set_lvl(VEC[v][39:8]);
      chk($sformatf("R2 irq vec%0d", v), 32'(irq[0]), 32'(VEC[v][4:0] != 0));
      claim(0, id);
      chk($sformatf("R3 winner vec%0d", v), 32'(id), 32'(VEC[v][4:0]));
      if (id != 0) cmpl(id);
      set_lvl('0);
    end

    // R4 masking while level stays high, R6 completion and range
    wr_thr(0, 0);
    set_lvl(32'h20);
    chk("R7 irq on level", 32'(irq[0]), 32'd1);
    claim(0, id);
    chk("R4 claim 5", 32'(id), 32'd5);
    tick();
    chk("R4 masked irq", 32'(irq[0]), 32'd0);
    claim(0, id);
    chk("R4 masked claim", 32'(id), 32'd0);
    cmpl(37);
    chk("R6 out-of-range ignored", 32'(irq[0]), 32'd0);
    cmpl(5);
    chk("R6 R10 release", 32'(irq[0]), 32'd1);
    claim(0, id);
    chk("R6 reclaim", 32'(id), 32'd5);
    cmpl(5);
    set_lvl('0);

    // R1 enable per context, claim hides source from all contexts
    set_lvl(32'h200);
    chk("R1 disabled ctx1", 32'(irq[1]), 32'd0);
    wr_en(1, 32'h200);
    chk("R1 R10 enabled ctx1", 32'(irq[1]), 32'd1);
    claim(1, id);
    chk("R1 ctx1 claim", 32'(id), 32'd9);
    chk("R4 hidden from ctx0", 32'(irq[0]), 32'd0);
    cmpl(9);
    set_lvl('0);

    // R7 level drop before claim
    set_lvl(32'h20);
    set_lvl('0);
    chk("R7 drop irq", 32'(irq[0]), 32'd0);
    claim(0, id);
    chk("R7 drop claim", 32'(id), 32'd0);

    // R2 R10 threshold equality
    set_lvl(32'h20);
    wr_thr(0, 5);
    chk("R2 equal threshold", 32'(irq[0]), 32'd0);
    wr_thr(0, 4);
    chk("R2 below priority", 32'(irq[0]), 32'd1);

    // R8 priority zero
    wr_prio(5, 0);
    chk("R8 prio zero irq", 32'(irq[0]), 32'd0);
    claim(0, id);
    chk("R5 nothing to claim", 32'(id), 32'd0);
    wr_prio(5, 5);
    chk("R10 prio restored", 32'(irq[0]), 32'd1);

    // R9 mid-run reset clears configuration
    rst = 1; tick(); rst = 0;
    tick();
    chk("R9 irq cleared", 32'(irq), 32'd0);
    wr_en(0, '1);
    wr_thr(0, 0);
    chk("R9 priority cleared", 32'(irq[0]), 32'd0);
    claim(0, id);
    chk("R9 claim after reset", 32'(id), 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule